// File: doc/BRIEF.md
# Toggle-Triggered Single-Port RAM Interface

This block wraps a word-organised storage array for a controller built as a state machine with a separate datapath. The datapath never touches the array itself. It presents a byte address, a write-enable and write data. It then asks for one access by inverting a request flag relative to the value it held before.

The wrapper serves that one load or store on the next falling clock edge. Read data is therefore settled by the following rising edge, when the datapath consumes it. After serving a request, the wrapper copies the flag into its own enable register, so the interface goes quiet again without the datapath clearing anything.

The byte address is rebased by a parameterised base offset and divided by four to form the word index. Each datapath state can use at most one word read from the storage, and it may send its result either back to the storage or to a register.

Top module: `tgram_top`

## Requirements
- R1: Synchronous active-high reset, sampled on the falling edge, clears the read-data output to zero and clears the internal enable to 0. After reset, the first request is the request flag going from 0 to 1.
- R2: While the request flag equals the internal enable, nothing is pending. Neither the array nor the read-data output changes, whatever the write-enable, address and write data do.
- R3: A pending request with write-enable high stores the write data at the word index. The read-data output keeps its value.
- R4: A pending request with write-enable low places the word at the word index on the read-data output. The value is valid at the rising edge that follows the serving falling edge.
- R5: The word index is (byte address − BASE_ADDR) shifted right by 2. The two low address bits select nothing.
- R6: An address below BASE_ADDR, or one whose index is DEPTH or more, is out of range. An out-of-range write changes no word, including the word its truncated index would alias. An out-of-range read returns zero.
- R7: Toggles on consecutive cycles are each served once and in order. A read that directly follows a write to the same word returns the new data.
- R8: Reset does not alter the array contents.
- R9: After every falling edge outside reset, the internal enable equals the request flag sampled at that edge, so one toggle yields exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the datapath uses the rising edge, the wrapper the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| req_tgl | input | 1 | Request flag; inverting it asks for one access |
| wr_en | input | 1 | 1 = store, 0 = load for the pending request |
| byte_addr | input | ADDR_W | Byte address of the access |
| wr_data | input | DATA_W | Word to store |
| rd_data | output | DATA_W | Registered word from the last load |

## Verification
The hardest situation to reach from the ports is the case where a held flag must change nothing while every other input moves. An idle period has no visible output by itself, so the bench fills held cycles with write-enable high and fresh addresses and data. It then reads the touched words back to prove the array kept them. Out-of-range writes are aimed at addresses whose truncated index aliases a real word, and that word is read afterwards. Back-to-back write-then-read pairs on consecutive cycles prove that each toggle is served at its own falling edge.

// File: rtl/tgram_pkg.sv
package tgram_pkg;
  localparam int unsigned BYTE_SHIFT = 2;

  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/tgram_addr.sv
module tgram_addr #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEPTH     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              idx_hit
);
  import tgram_pkg::*;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] word_full;

  always_comb begin
    offset    = byte_addr - BASE_ADDR;
    word_full = offset >> BYTE_SHIFT;
    word_idx  = word_full[IDX_W-1:0];
    idx_hit   = (byte_addr >= BASE_ADDR) && (word_full < ADDR_W'(DEPTH));
  end
endmodule

// File: rtl/tgram_tgl.sv
module tgram_tgl (
  input  logic clk,
  input  logic rst,
  input  logic req_tgl,
  output logic pending,
  output logic en_q
);
  always_ff @(negedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= req_tgl;
  end

  assign pending = (req_tgl ^ en_q) & ~rst;
endmodule

// File: rtl/tgram_array.sv
module tgram_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  tgram_pkg::acc_kind_e kind,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import tgram_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  // The only procedural block that reads or writes mem.
  always_ff @(negedge clk) begin
    if (acc && kind == ACC_STORE && hit)
      mem[idx] <= wdata;
    if (rst)
      rdata <= '0;
    else if (acc && kind == ACC_LOAD)
      rdata <= hit ? mem[idx] : '0;
  end
endmodule

// File: rtl/tgram_top.sv
module tgram_top #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEPTH     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  import tgram_pkg::*;

  localparam int unsigned IDX_W = idx_bits(DEPTH);

  logic             pending;
  logic             int_en_q;
  logic [IDX_W-1:0] word_idx;
  logic             idx_hit;
  acc_kind_e        kind;

  assign kind = wr_en ? ACC_STORE : ACC_LOAD;

  tgram_addr #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
  ) u_addr (
    .byte_addr(byte_addr), .word_idx(word_idx), .idx_hit(idx_hit)
  );

  tgram_tgl u_tgl (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .pending(pending), .en_q(int_en_q)
  );

  tgram_array #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst(rst), .acc(pending), .kind(kind), .hit(idx_hit),
    .idx(word_idx), .wdata(wr_data), .rdata(rd_data)
  );
endmodule

// File: rtl/tgram_chk.sv
module tgram_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_tgl,
  input logic              wr_en,
  input logic              int_en,
  input logic              idx_hit,
  input logic [DATA_W-1:0] rd_data
);
  assert_idle_stable_R2: assert property (@(negedge clk) disable iff (rst)
    (req_tgl == int_en) |=> $stable(rd_data));

  assert_store_keeps_rd_R3: assert property (@(negedge clk) disable iff (rst)
    (req_tgl != int_en && wr_en) |=> $stable(rd_data));

  assert_miss_reads_zero_R6: assert property (@(negedge clk) disable iff (rst)
    (req_tgl != int_en && !wr_en && !idx_hit) |=> (rd_data == '0));

  assert_enable_follows_R9: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> (int_en == $past(req_tgl)));

  assert_reset_clears_R1: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && int_en == 1'b0));
endmodule

bind tgram_top tgram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_tgl(req_tgl), .wr_en(wr_en),
  .int_en(int_en_q), .idx_hit(idx_hit), .rd_data(rd_data)
);

// File: tb/tgram_top_bench.sv
module tgram_top_bench;
  localparam int DEPTH = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_tgl = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] byte_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model [DEPTH];

  always #2 clk = ~clk;

  tgram_top u_tgram_top (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .wr_en(wr_en),
    .byte_addr(byte_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int s);
    return (32'(i) * 32'h9E37_79B1) ^ (32'h5A5A_0000 + 32'(s));
  endfunction

  // Toggle the flag with new inputs; returns one rising edge later (+1).
  task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] d);
    req_tgl   = ~req_tgl;
    wr_en     = we;
    byte_addr = a;
    wr_data   = d;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] waddr(input int i);
    return BASE + 32'(4 * i);
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1 reset rd_data", rd_data, 32'h0);

    // R3: store every word; rd_data stays 0
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = pat(i, 1);
      issue(1'b1, waddr(i), model[i]);
      chk("R3 store keeps rd_data", rd_data, 32'h0);
    end

    // R4 R5 R7: back-to-back loads with low bits set
    for (int i = 0; i < DEPTH; i++) begin
      issue(1'b0, waddr(i) + 32'(i % 4), 32'hDEAD_0000);
      chk("R4 R5 load", rd_data, model[i]);
    end

    // R2: held flag, moving inputs
    held = rd_data;
    for (int k = 0; k < 6; k++) begin
      wr_en = 1'b1; byte_addr = waddr(k + 3); wr_data = 32'hBAD0_0000 + 32'(k);
      @(posedge clk); #1;
      chk("R2 held rd_data", rd_data, held);
    end
    for (int k = 0; k < 6; k++) begin
      issue(1'b0, waddr(k + 3), 32'h0);
      chk("R2 array untouched", rd_data, model[k + 3]);
    end

    // R6: out-of-range writes, aliasing checks, zero reads
    issue(1'b1, waddr(DEPTH), 32'hFFFF_0001);
    issue(1'b1, BASE - 32'd4, 32'hFFFF_0002);
    issue(1'b0, waddr(0), 32'h0);
    chk("R6 alias word 0", rd_data, model[0]);
    issue(1'b0, waddr(DEPTH - 1), 32'h0);
    chk("R6 alias word last", rd_data, model[DEPTH - 1]);
    issue(1'b0, waddr(DEPTH), 32'h0);
    chk("R6 high miss reads 0", rd_data, 32'h0);
    issue(1'b0, waddr(DEPTH - 1), 32'h0);
    issue(1'b0, BASE - 32'd4, 32'h0);
    chk("R6 low miss reads 0", rd_data, 32'h0);

    // R7: write then read same word on consecutive cycles
    for (int i = DEPTH - 1; i >= 0; i--) begin
      model[i] = pat(i, 2);
      issue(1'b1, waddr(i), model[i]);
      issue(1'b0, waddr(i), 32'h0);
      chk("R7 write-then-read", rd_data, model[i]);
    end

    // R8 / R1: reset mid-run keeps array
    rst = 1'b1;
    req_tgl = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1 reset clears rd_data", rd_data, 32'h0);
    for (int i = 0; i < DEPTH; i += 7) begin
      issue(1'b0, waddr(i), 32'h0);
      chk("R8 contents kept", rd_data, model[i]);
    end

    // R9: one toggle, one access; then hold
    issue(1'b0, waddr(2), 32'h0);
    chk("R9 single load", rd_data, model[2]);
    byte_addr = waddr(9);
    @(posedge clk); #1;
    chk("R9 no repeat access", rd_data, model[2]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule